// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries 18-bit words from a write clock domain to an independent read clock domain. Both ports sample their controls on the rising edge of their own clock. Each port has an active-low enable and a direction control: the write side acts only when its direction selects write, and the read side acts only when its direction selects read. This lets the block sit behind one half of a bidirectional port pair, with one instance for each direction of traffic.

Four active-low status flags are produced. Empty and almost-empty are registered in the read domain. Full and almost-full are registered in the write domain. The two thresholds live in offset registers. Each offset register is loaded from the port on whose clock its flag runs. The read and write pointers cross between the domains in Gray code through two-flop synchronisers. Each flag compares the local pointer with the synchronised copy of the remote pointer. As a result, a flag that waits on the other domain can release late but can never assert late. DEPTH must be a power of two (256 by default, 512 is also supported).

Top module: `async_flag_fifo`

## Requirements
- R1: A word is stored at a rising `wr_clk_i` edge only when `wr_en_ni`=0, `wr_dir_i`=0 (the write code) and `full_no`=1. With `wr_en_ni`=1, or with `wr_dir_i`=1, nothing is stored.
- R2: At a rising `rd_clk_i` edge with `rd_en_ni`=0, `rd_dir_i`=1 (the read code) and `empty_no`=1, the oldest word is loaded into `rd_data_o` and is visible after that same edge. In every other cycle `rd_data_o` holds its value.
- R3: `empty_no` is low while the read domain sees no stored word. A read attempted while it is low changes neither `rd_data_o` nor the read position.
- R4: `full_no` is low while DEPTH words are stored. A write attempted while it is low is discarded, and its word never appears at the read port.
- R5: `almost_empty_no` is low when the stored count is less than or equal to the almost-empty offset, and high when the count is above it.
- R6: `almost_full_no` is low when the stored count is greater than DEPTH minus the almost-full offset, and high otherwise.
- R7: Both offsets are 8 after reset. A high `ae_load_i` at a `rd_clk_i` edge loads `ae_value_i`, and a high `af_load_i` at a `wr_clk_i` edge loads `af_value_i`. A value above DEPTH is clamped to DEPTH. The new offset governs the flag from that same edge on.
- R8: While `rst_ni` is low, asynchronously, the FIFO is empty, `empty_no`=0, `almost_empty_no`=0, `full_no`=1, `almost_full_no`=1 and `rd_data_o`=0.
- R9: Words leave in the order they were stored, with all 18 bits intact.
- R10: `full_no` falls on the very `wr_clk_i` edge that stores the DEPTH-th word. `empty_no` falls on the very `rd_clk_i` edge that removes the last word. Only the release of a flag may lag, by the synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write domain clock |
| rd_clk_i | input | 1 | Read domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wr_en_ni | input | 1 | Write port enable, active low |
| wr_dir_i | input | 1 | Write port direction, 0 selects write |
| wr_data_i | input | 18 | Word to store |
| af_load_i | input | 1 | Load strobe for almost-full offset (write clock) |
| af_value_i | input | 9 | Almost-full offset value |
| full_no | output | 1 | Full flag, active low, write domain |
| almost_full_no | output | 1 | Almost-full flag, active low, write domain |
| rd_en_ni | input | 1 | Read port enable, active low |
| rd_dir_i | input | 1 | Read port direction, 1 selects read |
| rd_data_o | output | 18 | Registered read word |
| ae_load_i | input | 1 | Load strobe for almost-empty offset (read clock) |
| ae_value_i | input | 9 | Almost-empty offset value |
| empty_no | output | 1 | Empty flag, active low, read domain |
| almost_empty_no | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The hardest cases are the exact edges where full and empty assert. They have to be reached with the synchronised remote pointer fully caught up, so that only the local pointer moves the flag. The stimulus fills or drains to one word short of the boundary, then idles both clocks long enough for the pointers to cross. After that it issues the single last transfer and samples the flag right after that edge. A write rejected while full is told apart from a stored one by giving it a unique data value and draining the FIFO afterwards. A read rejected while empty is told apart by checking that the next real word still comes out in order.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
  typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} port_dir_e;

  localparam int unsigned OFFSET_RESET = 8;
  localparam int unsigned PTR_MAX_W    = 16;

  function automatic logic [PTR_MAX_W-1:0] bin_to_gray(input logic [PTR_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX_W-1:0] gray_to_bin(input logic [PTR_MAX_W-1:0] g);
    logic [PTR_MAX_W-1:0] b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/afifo_ptr_sync.sv
`timescale 1ns/1ps
module afifo_ptr_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/afifo_mem.sv
`timescale 1ns/1ps
module afifo_mem #(
  parameter int unsigned DW    = 18,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          wr_clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wr_clk_i) begin
    if (wr_en_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/afifo_wr_side.sv
`timescale 1ns/1ps
module afifo_wr_side
  import afifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned PW    = AW + 1
) (
  input  logic          wr_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_ni,
  input  logic          wr_dir_i,
  input  logic          af_load_i,
  input  logic [PW-1:0] af_value_i,
  input  logic [PW-1:0] rgray_sync_i,
  output logic          wr_fire_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_no,
  output logic          almost_full_no,
  output logic [PW-1:0] af_off_o
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] OFF_INIT = PW'(OFFSET_RESET);

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, rbin_s, cnt_d, off_q, off_d;
  logic          full_nq, afull_nq, fire;

  always_comb begin
    rbin_s = PW'(gray_to_bin(PTR_MAX_W'(rgray_sync_i)));
    fire   = !wr_en_ni && (wr_dir_i == DIR_WRITE) && full_nq;
    wbin_d = wbin_q + PW'(fire);
    // stale read pointer overestimates the count: flags assert early, never late
    cnt_d  = wbin_d - rbin_s;
    off_d  = off_q;
    if (af_load_i) off_d = (af_value_i > FULL_CNT) ? FULL_CNT : af_value_i;
  end

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q   <= '0;
      wgray_q  <= '0;
      full_nq  <= 1'b1;
      afull_nq <= 1'b1;
      off_q    <= OFF_INIT;
    end else begin
      wbin_q   <= wbin_d;
      wgray_q  <= PW'(bin_to_gray(PTR_MAX_W'(wbin_d)));
      full_nq  <= (cnt_d != FULL_CNT);
      afull_nq <= !(cnt_d > (FULL_CNT - off_d));
      off_q    <= off_d;
    end
  end

  assign wr_fire_o      = fire;
  assign waddr_o        = wbin_q[AW-1:0];
  assign wgray_o        = wgray_q;
  assign full_no        = full_nq;
  assign almost_full_no = afull_nq;
  assign af_off_o       = off_q;
endmodule

// File: rtl/afifo_rd_side.sv
`timescale 1ns/1ps
module afifo_rd_side
  import afifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned PW    = AW + 1
) (
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_ni,
  input  logic          rd_dir_i,
  input  logic          ae_load_i,
  input  logic [PW-1:0] ae_value_i,
  input  logic [PW-1:0] wgray_sync_i,
  output logic          rd_fire_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic          empty_no,
  output logic          almost_empty_no,
  output logic [PW-1:0] ae_off_o
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] OFF_INIT = PW'(OFFSET_RESET);

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, wbin_s, cnt_d, off_q, off_d;
  logic          empty_nq, aempty_nq, fire;

  always_comb begin
    wbin_s = PW'(gray_to_bin(PTR_MAX_W'(wgray_sync_i)));
    fire   = !rd_en_ni && (rd_dir_i == DIR_READ) && empty_nq;
    rbin_d = rbin_q + PW'(fire);
    // stale write pointer underestimates the count: flags assert early, never late
    cnt_d  = wbin_s - rbin_d;
    off_d  = off_q;
    if (ae_load_i) off_d = (ae_value_i > FULL_CNT) ? FULL_CNT : ae_value_i;
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q    <= '0;
      rgray_q   <= '0;
      empty_nq  <= 1'b0;
      aempty_nq <= 1'b0;
      off_q     <= OFF_INIT;
    end else begin
      rbin_q    <= rbin_d;
      rgray_q   <= PW'(bin_to_gray(PTR_MAX_W'(rbin_d)));
      empty_nq  <= (cnt_d != '0);
      aempty_nq <= (cnt_d > off_d);
      off_q     <= off_d;
    end
  end

  assign rd_fire_o       = fire;
  assign raddr_o         = rbin_q[AW-1:0];
  assign rgray_o         = rgray_q;
  assign empty_no        = empty_nq;
  assign almost_empty_no = aempty_nq;
  assign ae_off_o        = off_q;
endmodule

// File: rtl/async_flag_fifo.sv
`timescale 1ns/1ps
module async_flag_fifo #(
  parameter int unsigned DW          = 18,
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW         = $clog2(DEPTH),
  localparam int unsigned PW         = AW + 1
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_ni,
  input  logic          wr_dir_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          af_load_i,
  input  logic [PW-1:0] af_value_i,
  output logic          full_no,
  output logic          almost_full_no,
  input  logic          rd_en_ni,
  input  logic          rd_dir_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          ae_load_i,
  input  logic [PW-1:0] ae_value_i,
  output logic          empty_no,
  output logic          almost_empty_no
);
  logic          wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_sync, rgray_sync;
  logic [PW-1:0] af_off, ae_off;

  afifo_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wr_clk_i      (wr_clk_i),
    .rst_ni        (rst_ni),
    .wr_en_ni      (wr_en_ni),
    .wr_dir_i      (wr_dir_i),
    .af_load_i     (af_load_i),
    .af_value_i    (af_value_i),
    .rgray_sync_i  (rgray_sync),
    .wr_fire_o     (wr_fire),
    .waddr_o       (waddr),
    .wgray_o       (wgray),
    .full_no       (full_no),
    .almost_full_no(almost_full_no),
    .af_off_o      (af_off)
  );

  afifo_rd_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .rd_clk_i       (rd_clk_i),
    .rst_ni         (rst_ni),
    .rd_en_ni       (rd_en_ni),
    .rd_dir_i       (rd_dir_i),
    .ae_load_i      (ae_load_i),
    .ae_value_i     (ae_value_i),
    .wgray_sync_i   (wgray_sync),
    .rd_fire_o      (rd_fire),
    .raddr_o        (raddr),
    .rgray_o        (rgray),
    .empty_no       (empty_no),
    .almost_empty_no(almost_empty_no),
    .ae_off_o       (ae_off)
  );

  afifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .async_i(wgray),
    .sync_o (wgray_sync)
  );

  afifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .async_i(rgray),
    .sync_o (rgray_sync)
  );

  afifo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wr_clk_i(wr_clk_i),
    .wr_en_i (wr_fire),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .rd_clk_i(rd_clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_fire),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/async_flag_fifo_chk.sv
`timescale 1ns/1ps
module async_flag_fifo_chk #(
  parameter int unsigned DW = 18,
  parameter int unsigned PW = 9
) (
  input logic          wr_clk_i,
  input logic          rd_clk_i,
  input logic          rst_ni,
  input logic          full_no,
  input logic          almost_full_no,
  input logic          empty_no,
  input logic          almost_empty_no,
  input logic          rd_en_ni,
  input logic          rd_dir_i,
  input logic [DW-1:0] rd_data_o,
  input logic          af_load_i,
  input logic [PW-1:0] af_value_i,
  input logic          ae_load_i,
  input logic [PW-1:0] ae_value_i,
  input logic [PW-1:0] af_off,
  input logic [PW-1:0] ae_off
);
  localparam logic [PW-1:0] DEPTH_C = PW'(1 << (PW - 1));

  p_full_implies_af_r6: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (!full_no && af_off != '0) |-> !almost_full_no);

  p_empty_implies_ae_r5: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !empty_no |-> !almost_empty_no);

  p_rdata_idle_r2: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_en_ni || !rd_dir_i) |=> $stable(rd_data_o));

  p_rdata_empty_r3: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (!rd_en_ni && rd_dir_i && !empty_no) |=> $stable(rd_data_o));

  p_af_load_r7: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (af_load_i && af_value_i <= DEPTH_C) |=> (af_off == $past(af_value_i)));

  p_ae_load_r7: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (ae_load_i && ae_value_i <= DEPTH_C) |=> (ae_off == $past(ae_value_i)));

  p_af_clamp_r7: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (af_load_i && af_value_i > DEPTH_C) |=> (af_off == DEPTH_C));
endmodule

bind async_flag_fifo async_flag_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
  .wr_clk_i       (wr_clk_i),
  .rd_clk_i       (rd_clk_i),
  .rst_ni         (rst_ni),
  .full_no        (full_no),
  .almost_full_no (almost_full_no),
  .empty_no       (empty_no),
  .almost_empty_no(almost_empty_no),
  .rd_en_ni       (rd_en_ni),
  .rd_dir_i       (rd_dir_i),
  .rd_data_o      (rd_data_o),
  .af_load_i      (af_load_i),
  .af_value_i     (af_value_i),
  .ae_load_i      (ae_load_i),
  .ae_value_i     (ae_value_i),
  .af_off         (af_off),
  .ae_off         (ae_off)
);

// File: tb/tb_async_flag_fifo.sv
`timescale 1ns/1ps
module tb_async_flag_fifo;
  localparam int DW    = 18;
  localparam int DEPTH = 256;
  localparam int PW    = 9;
  localparam int NV    = 7;

  // {writes[21:13], reads[12:4], expected {empty_no, almost_empty_no, almost_full_no, full_no}}
  localparam logic [21:0] VEC [NV] = '{
    {9'd1,   9'd0,   4'b1011},
    {9'd8,   9'd0,   4'b1111},
    {9'd0,   9'd1,   4'b1011},
    {9'd240, 9'd0,   4'b1111},
    {9'd1,   9'd0,   4'b1101},
    {9'd7,   9'd0,   4'b1100},
    {9'd0,   9'd256, 4'b0011}
  };

  logic          wr_clk_i = 1'b0, rd_clk_i = 1'b0, rst_ni = 1'b0;
  logic          wr_en_ni = 1'b1, wr_dir_i = 1'b0, af_load_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [PW-1:0] af_value_i = '0, ae_value_i = '0;
  logic          rd_en_ni = 1'b1, rd_dir_i = 1'b1, ae_load_i = 1'b0;
  logic          full_no, almost_full_no, empty_no, almost_empty_no;
  logic [DW-1:0] rd_data_o;

  int n_checks = 0, n_err = 0, wr_idx = 0, rd_idx = 0;

  always #2 wr_clk_i = ~wr_clk_i;
  always #3 rd_clk_i = ~rd_clk_i;

  async_flag_fifo dut (.*);

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 11) ^ (i << 10) ^ 18'h2AAAA);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk_i);
    repeat (6) @(negedge wr_clk_i);
  endtask

  task automatic write_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk_i);
      wr_en_ni = 1'b0; wr_dir_i = 1'b0; wr_data_i = pat(wr_idx);
      wr_idx++;
    end
    @(negedge wr_clk_i);
    wr_en_ni = 1'b1;
  endtask

  task automatic read_burst(input int n);
    @(negedge rd_clk_i);
    rd_en_ni = 1'b0; rd_dir_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk_i);
      check(32'(rd_data_o), 32'(pat(rd_idx)), "R9 read order/data");
      rd_idx++;
      if (i == n - 1) rd_en_ni = 1'b1;
    end
  endtask

  task automatic flags(input logic [3:0] exp, input string what);
    check(32'({empty_no, almost_empty_no, almost_full_no, full_no}), 32'(exp), what);
  endtask

  initial begin
    logic [DW-1:0] held;
    #10;
    flags(4'b0011, "R8 flags in reset");
    check(32'(rd_data_o), 32'h0, "R8 rd_data_o in reset");
    @(negedge wr_clk_i); rst_ni = 1'b1;
    settle();
    flags(4'b0011, "R8 flags after reset");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][21:13] != 0) write_burst(int'(VEC[v][21:13]));
      if (VEC[v][12:4] != 0)  read_burst(int'(VEC[v][12:4]));
      settle();
      flags(VEC[v][3:0], $sformatf("R3/R4/R5/R6 flags vector %0d", v));
    end

    // R1: disabled or wrong-direction write stores nothing
    @(negedge wr_clk_i); wr_en_ni = 1'b1; wr_dir_i = 1'b0; wr_data_i = 18'h15555;
    @(negedge wr_clk_i); wr_en_ni = 1'b0; wr_dir_i = 1'b1;
    @(negedge wr_clk_i); wr_en_ni = 1'b1; wr_dir_i = 1'b0;
    settle();
    check(32'(empty_no), 32'h0, "R1 ignored write leaves FIFO empty");

    // R3: read while empty changes nothing
    held = rd_data_o;
    @(negedge rd_clk_i); rd_en_ni = 1'b0; rd_dir_i = 1'b1;
    repeat (3) @(negedge rd_clk_i);
    rd_en_ni = 1'b1;
    check(32'(rd_data_o), 32'(held), "R3 rd_data_o held on empty read");
    write_burst(1);
    settle();
    read_burst(1);

    // R2: disabled or wrong-direction read moves nothing
    write_burst(1);
    settle();
    held = rd_data_o;
    @(negedge rd_clk_i); rd_en_ni = 1'b0; rd_dir_i = 1'b0;
    @(negedge rd_clk_i); rd_en_ni = 1'b1; rd_dir_i = 1'b1;
    @(negedge rd_clk_i);
    check(32'(rd_data_o), 32'(held), "R2 rd_data_o held without read");
    check(32'(empty_no), 32'h1, "R2 word still stored");
    read_burst(1);
    settle();

    // R10 / R4: exact full edge, rejected write when full
    write_burst(DEPTH - 1);
    settle();
    check(32'(full_no), 32'h1, "R10 not full one word short");
    write_burst(1);
    check(32'(full_no), 32'h0, "R10 full on DEPTH-th write edge");
    @(negedge wr_clk_i); wr_en_ni = 1'b0; wr_dir_i = 1'b0; wr_data_i = 18'h3FFFF;
    @(negedge wr_clk_i); wr_en_ni = 1'b1;
    check(32'(full_no), 32'h0, "R4 still full after rejected write");
    settle();
    read_burst(DEPTH - 1);
    settle();
    check(32'(empty_no), 32'h1, "R10 not empty one word short");
    read_burst(1);
    check(32'(empty_no), 32'h0, "R10 empty on last read edge");
    settle();
    check(32'(empty_no), 32'h0, "R4 rejected word never stored");

    // R7: programmed offsets
    @(negedge rd_clk_i); ae_load_i = 1'b1; ae_value_i = 9'd2;
    @(negedge rd_clk_i); ae_load_i = 1'b0;
    @(negedge wr_clk_i); af_load_i = 1'b1; af_value_i = 9'd3;
    @(negedge wr_clk_i); af_load_i = 1'b0;
    write_burst(3);
    settle();
    check(32'(almost_empty_no), 32'h1, "R7 R5 count 3 above offset 2");
    read_burst(1);
    settle();
    check(32'(almost_empty_no), 32'h0, "R7 R5 count 2 at offset 2");
    write_burst(251);
    settle();
    check(32'(almost_full_no), 32'h1, "R7 R6 count 253 at limit");
    write_burst(1);
    settle();
    check(32'(almost_full_no), 32'h0, "R7 R6 count 254 above limit");

    // R8 mid-run reset, R7 offsets back to 8
    @(negedge wr_clk_i); rst_ni = 1'b0;
    #1;
    flags(4'b0011, "R8 flags on mid-run reset");
    check(32'(rd_data_o), 32'h0, "R8 rd_data_o on mid-run reset");
    @(negedge wr_clk_i); rst_ni = 1'b1;
    wr_idx = 0; rd_idx = 0;
    settle();
    write_burst(9);
    settle();
    check(32'(almost_empty_no), 32'h1, "R7 default offset, count 9");
    read_burst(1);
    settle();
    check(32'(almost_empty_no), 32'h0, "R7 default offset, count 8");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #400000;
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule